// File: doc/BRIEF.md
# Pulse Statistics Calibrator

This block learns the three parameters that a pulse front end needs before it can time or normalize events: a trigger threshold, the average pulse length and the average pulse energy. It takes a baseline-subtracted sample stream, one sample per clock, and the current pulse-side half-width of an adaptive baseline window that has already settled. A start strobe launches a calibration run, and a later strobe restarts it.

A run has three phases, and each phase depends on the result of the one before it. First, the window half-width is averaged over a fixed number of consecutive cycles to give the threshold. Next, pulses are detected against that threshold and their lengths are averaged. Last, pulses are detected again and their sample sums are averaged, each sum taken over exactly the learned average length. After every accepted pulse a long holdoff blocks the next acceptance. This keeps a sudden baseline jump from filling the averages with bad data. Each average covers N = 2^AVG_LOG2 observations and is formed by an arithmetic right shift of a wide accumulator.

Top module: `pulse_stat_cal`

## Requirements
- R1: After reset, `threshold`, `avgLen` and `avgEnergy` are 0 and `done` is 0. Until `start` is seen, sample and half-width inputs change nothing.
- R2: In the N cycles after a `start` cycle, the block sums `halfWidth`. At the edge of the Nth of these cycles, `threshold` becomes floor(sum/N) and the length phase begins. `threshold` then holds until the next `start`.
- R3: A pulse is detected only on the sample that completes a run of exactly RUN_LEN consecutive samples that are strictly greater than `threshold` (signed compare). Shorter runs are ignored, and a run that continues past RUN_LEN does not detect again until a sample at or below threshold breaks it.
- R4: In the length phase, the recorded length counts the consecutive above-threshold samples of a detected pulse, including its first RUN_LEN samples. It closes on the first sample at or below threshold. After N pulses, `avgLen` becomes floor(sum of lengths / N) and the energy phase begins.
- R5: A pulse length saturates at 2^LEN_W-1. When a pulse is still above threshold at that count, it closes with the capped value on the next sample.
- R6: After a pulse closes, in either the length or the energy phase, no detection is accepted during the next HOLDOFF samples.
- R7: In the energy phase, a pulse's energy is the signed sum of `avgLen` consecutive samples, starting at the first sample of the detecting run, whatever their level. After N pulses, `avgEnergy` becomes floor(sum / N), rounding toward minus infinity.
- R8: When the energy phase ends, `done` rises and all outputs then hold whatever the inputs do, until `start`.
- R9: `start` in any phase clears the outputs and `done` on the next edge and restarts the threshold phase. It also clears the pulse tracking, the holdoff and the observation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart calibration |
| sample | input | DATA_W | Baseline-subtracted sample, signed |
| halfWidth | input | HW_W | Pulse-side half-width of the baseline window |
| threshold | output | HW_W | Learned trigger threshold |
| avgLen | output | LEN_W | Learned average pulse length in samples |
| avgEnergy | output | DATA_W+LEN_W | Learned average pulse energy, signed |
| done | output | 1 | All three parameters are valid |

## Verification
The assertions assume several things about the inputs. `threshold` fits below the positive range of `sample` (HW_W < DATA_W). RUN_LEN is at least 2 and no greater than 2^LEN_W-1. HOLDOFF is at least 1. The stimulus uses such a configuration with a short holdoff and only four observations per phase, so a full run plus a restart fits in a few hundred cycles. The pulse trains include a run that is too short, a pulse that arrives inside the holdoff in each pulse phase, a pulse longer than the length cap, and an energy pulse whose tail drops below zero. The final averages therefore differ from what any one missing rule would give.

// File: rtl/pulse_cal_pkg.sv
package pulse_cal_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_THRESH,
    PH_LENGTH,
    PH_ENERGY,
    PH_DONE
  } calPhase_e;

  typedef struct packed {
    logic      clearAll;
    calPhase_e phase;
    logic      lastObs;
  } calCtrl_t;

endpackage

// File: rtl/pulse_cal_ctrl.sv
module pulse_cal_ctrl
  import pulse_cal_pkg::*;
#(
  parameter int AVG_LOG2 = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     obsEvent,
  output calCtrl_t ctrl,
  output logic     done
);

  calPhase_e           phase;
  logic [AVG_LOG2-1:0] obsCnt;
  logic                lastObs;

  assign lastObs = (obsCnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      obsCnt <= '0;
    end else if (start) begin
      phase  <= PH_THRESH;
      obsCnt <= '0;
    end else if (obsEvent) begin
      obsCnt <= obsCnt + 1'b1;
      if (lastObs) begin
        unique case (phase)
          PH_THRESH: phase <= PH_LENGTH;
          PH_LENGTH: phase <= PH_ENERGY;
          PH_ENERGY: phase <= PH_DONE;
          default:   phase <= phase;
        endcase
      end
    end
  end

  always_comb begin
    ctrl.clearAll = start;
    ctrl.phase    = phase;
    ctrl.lastObs  = lastObs;
  end

  assign done = (phase == PH_DONE);

  // R8: the finished state is held until a new start
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && !start) |=> (phase == PH_DONE));

  // R9: start always lands in the threshold phase
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == PH_THRESH && obsCnt == '0));

endmodule

// File: rtl/pulse_cal_dp.sv
module pulse_cal_dp
  import pulse_cal_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int HW_W     = 8,
  parameter int AVG_LOG2 = 10,
  parameter int RUN_LEN  = 8,
  parameter int HOLDOFF  = 65536,
  parameter int LEN_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  calCtrl_t                       ctrl,
  input  logic signed [DATA_W-1:0]       sample,
  input  logic        [HW_W-1:0]         halfWidth,
  output logic        [HW_W-1:0]         threshold,
  output logic        [LEN_W-1:0]        avgLen,
  output logic signed [DATA_W+LEN_W-1:0] avgEnergy,
  output logic                           obsEvent
);

  localparam int EN_W    = DATA_W + LEN_W;
  localparam int ACC_W   = EN_W + AVG_LOG2;
  localparam int RUN_W   = $clog2(RUN_LEN + 1);
  localparam int HOLD_W  = $clog2(HOLDOFF + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic signed [DATA_W-1:0] hist [RUN_LEN-1];
  logic signed [EN_W-1:0]   winSum, sampleExt, curSum, obsVal, enFinal;
  logic signed [ACC_W-1:0]  acc, accNext, result;
  logic [RUN_W-1:0]         runCnt;
  logic [HOLD_W-1:0]        holdCnt;
  logic [LEN_W-1:0]         curLen, remain, remainInit;
  logic                     tracking, above, pulsePhase, inLen, inEn;
  logic                     runDone, acceptEvt, closeLen, closeEn;

  assign inLen      = (ctrl.phase == PH_LENGTH);
  assign inEn       = (ctrl.phase == PH_ENERGY);
  assign pulsePhase = inLen || inEn;
  assign above      = sample > $signed({{(DATA_W-HW_W){1'b0}}, threshold});
  assign sampleExt  = EN_W'(sample);

  // delay line of the previous RUN_LEN-1 samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist[0] <= '0;
    else        hist[0] <= sample;
  end
  for (genvar g = 1; g < RUN_LEN - 1; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist[g] <= '0;
      else        hist[g] <= hist[g-1];
    end
  end

  always_comb begin
    winSum = sampleExt;
    for (int i = 0; i < RUN_LEN - 1; i++) winSum = winSum + EN_W'(hist[i]);
  end

  assign runDone    = pulsePhase && above && !tracking && (runCnt == RUN_W'(RUN_LEN - 1));
  assign acceptEvt  = runDone && (holdCnt == '0);
  assign remainInit = avgLen - LEN_W'(RUN_LEN);
  assign closeLen   = inLen && tracking && (!above || curLen == LEN_MAX);
  assign closeEn    = inEn && ((acceptEvt && remainInit == '0) ||
                               (tracking && remain == LEN_W'(1)));
  assign enFinal    = acceptEvt ? winSum : (curSum + sampleExt);
  assign obsEvent   = (ctrl.phase == PH_THRESH) || closeLen || closeEn;

  always_comb begin
    unique case (ctrl.phase)
      PH_THRESH: obsVal = EN_W'(halfWidth);
      PH_LENGTH: obsVal = EN_W'(curLen);
      default:   obsVal = enFinal;
    endcase
  end

  assign accNext = acc + ACC_W'(obsVal);
  assign result  = accNext >>> AVG_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCnt <= '0;
    end else if (ctrl.clearAll || !pulsePhase || !above) begin
      runCnt <= '0;
    end else if (runCnt != RUN_W'(RUN_LEN)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   holdCnt <= '0;
    else if (ctrl.clearAll)       holdCnt <= '0;
    else if (closeLen || closeEn) holdCnt <= HOLD_W'(HOLDOFF);
    else if (holdCnt != '0)       holdCnt <= holdCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tracking <= 1'b0;
      curLen   <= '0;
      remain   <= '0;
      curSum   <= '0;
    end else if (ctrl.clearAll || !pulsePhase) begin
      tracking <= 1'b0;
    end else if (inLen) begin
      if (acceptEvt) begin
        tracking <= 1'b1;
        curLen   <= LEN_W'(RUN_LEN);
      end else if (closeLen) begin
        tracking <= 1'b0;
      end else if (tracking) begin
        curLen <= curLen + 1'b1;
      end
    end else begin
      if (acceptEvt) begin
        tracking <= (remainInit != '0);
        remain   <= remainInit;
        curSum   <= winSum;
      end else if (tracking) begin
        tracking <= (remain != LEN_W'(1));
        remain   <= remain - 1'b1;
        curSum   <= curSum + sampleExt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      threshold <= '0;
      avgLen    <= '0;
      avgEnergy <= '0;
    end else if (ctrl.clearAll) begin
      acc       <= '0;
      threshold <= '0;
      avgLen    <= '0;
      avgEnergy <= '0;
    end else if (obsEvent) begin
      if (ctrl.lastObs) begin
        acc <= '0;
        unique case (ctrl.phase)
          PH_THRESH: threshold <= HW_W'(result);
          PH_LENGTH: avgLen    <= LEN_W'(result);
          default:   avgEnergy <= EN_W'(result);
        endcase
      end else begin
        acc <= accNext;
      end
    end
  end

  // R2: the threshold moves only at the end of its own phase or on start
  a_r2_thresh_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.phase != PH_THRESH && !ctrl.clearAll) |=> $stable(threshold));

  // R3: a detection needs the previous sample above threshold as well
  a_r3_run_before_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acceptEvt |-> $past(above));

  // R5: a pulse at the length cap is closed on the next sample
  a_r5_cap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (inLen && tracking && curLen == LEN_MAX) |=> !tracking);

  // R6: no acceptance right after a pulse closes
  a_r6_holdoff_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (closeLen || closeEn) |=> !acceptEvt);

  // R9: start clears every learned value
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clearAll |=> (threshold == '0 && avgLen == '0 && avgEnergy == '0));

endmodule

// File: rtl/pulse_stat_cal.sv
module pulse_stat_cal
  import pulse_cal_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int HW_W     = 8,
  parameter int AVG_LOG2 = 10,
  parameter int RUN_LEN  = 8,
  parameter int HOLDOFF  = 65536,
  parameter int LEN_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic signed [DATA_W-1:0]       sample,
  input  logic        [HW_W-1:0]         halfWidth,
  output logic        [HW_W-1:0]         threshold,
  output logic        [LEN_W-1:0]        avgLen,
  output logic signed [DATA_W+LEN_W-1:0] avgEnergy,
  output logic                           done
);

  calCtrl_t ctrl;
  logic     obsEvent;

  pulse_cal_ctrl #(.AVG_LOG2(AVG_LOG2)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .obsEvent (obsEvent),
    .ctrl     (ctrl),
    .done     (done)
  );

  pulse_cal_dp #(
    .DATA_W   (DATA_W),
    .HW_W     (HW_W),
    .AVG_LOG2 (AVG_LOG2),
    .RUN_LEN  (RUN_LEN),
    .HOLDOFF  (HOLDOFF),
    .LEN_W    (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .sample    (sample),
    .halfWidth (halfWidth),
    .threshold (threshold),
    .avgLen    (avgLen),
    .avgEnergy (avgEnergy),
    .obsEvent  (obsEvent)
  );

endmodule

// File: tb/tb_pulse_stat_cal.sv
module tb_pulse_stat_cal;

  localparam int DATA_W = 12, HW_W = 8, AVG_LOG2 = 2, RUN_LEN = 4;
  localparam int HOLDOFF = 20, LEN_W = 5;
  localparam int N = 1 << AVG_LOG2;
  localparam int LMAX = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [DATA_W-1:0] sample = '0;
  logic [HW_W-1:0] halfWidth = '0;
  logic [HW_W-1:0] threshold;
  logic [LEN_W-1:0] avgLen;
  logic signed [DATA_W+LEN_W-1:0] avgEnergy;
  logic done;

  int checks = 0, failures = 0, cycles = 0;

  pulse_stat_cal #(.DATA_W(DATA_W), .HW_W(HW_W), .AVG_LOG2(AVG_LOG2),
    .RUN_LEN(RUN_LEN), .HOLDOFF(HOLDOFF), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sample(sample),
    .halfWidth(halfWidth), .threshold(threshold), .avgLen(avgLen),
    .avgEnergy(avgEnergy), .done(done));

  always #4 clk = ~clk;

  // behavioural reference model
  int mPhase, mObs, mThr, mLen, mEn, mRun, mCur, mRem, mHold;
  longint mAcc, mSum;
  bit mTrk;
  int mHist[$];

  task automatic mReset();
    mPhase = 0; mObs = 0; mThr = 0; mLen = 0; mEn = 0; mRun = 0;
    mCur = 0; mRem = 0; mHold = 0; mAcc = 0; mSum = 0; mTrk = 0;
    mHist.delete();
    for (int i = 0; i < RUN_LEN - 1; i++) mHist.push_back(0);
  endtask

  task automatic mRecord(longint v, inout bit rec);
    rec = 1;
    mAcc += v;
    mObs++;
    if (mObs == N) begin
      if (mPhase == 2) mLen = int'(mAcc >>> AVG_LOG2);
      else             mEn  = int'(mAcc >>> AVG_LOG2);
      mPhase++; mAcc = 0; mObs = 0;
    end
  endtask

  task automatic mStep(int s, int h, bit st);
    bit rec = 0;
    bit abv, acc;
    longint win;
    int ph;
    if (st) begin
      mPhase = 1; mObs = 0; mAcc = 0; mThr = 0; mLen = 0; mEn = 0;
      mRun = 0; mTrk = 0; mHold = 0;
    end else begin
      ph = mPhase;
      abv = (s > mThr);
      acc = (ph == 2 || ph == 3) && abv && !mTrk && mRun == RUN_LEN - 1 && mHold == 0;
      win = s;
      foreach (mHist[i]) win += mHist[i];
      if (ph == 1) begin
        mAcc += h; mObs++;
        if (mObs == N) begin
          mThr = int'(mAcc >>> AVG_LOG2); mAcc = 0; mObs = 0; mPhase = 2;
        end
      end else if (ph == 2) begin
        if (acc) begin mTrk = 1; mCur = RUN_LEN; end
        else if (mTrk && (!abv || mCur == LMAX)) begin mTrk = 0; mRecord(mCur, rec); end
        else if (mTrk) mCur++;
      end else if (ph == 3) begin
        if (acc) begin
          if (mLen - RUN_LEN == 0) mRecord(win, rec);
          else begin mTrk = 1; mRem = mLen - RUN_LEN; mSum = win; end
        end else if (mTrk) begin
          if (mRem == 1) begin mTrk = 0; mRecord(mSum + s, rec); end
          else begin mRem--; mSum += s; end
        end
      end
      if (ph == 2 || ph == 3) mRun = abv ? ((mRun < RUN_LEN) ? mRun + 1 : mRun) : 0;
      else begin mRun = 0; mTrk = 0; end
      if (rec) mHold = HOLDOFF;
      else if (mHold > 0) mHold--;
    end
    mHist.push_front(s);
    void'(mHist.pop_back());
  endtask

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmpAll();
    chk(threshold == mThr, "R2 threshold vs model", threshold, mThr);
    chk(avgLen == mLen, "R4 avgLen vs model", avgLen, mLen);
    chk($signed(avgEnergy) == mEn, "R7 avgEnergy vs model", $signed(avgEnergy), mEn);
    chk(done == (mPhase == 4), "R8 done vs model", done, mPhase == 4);
  endtask

  // one sample cycle: drive, advance model, then compare after the edge
  task automatic cyc(int s, int h, bit st);
    sample = DATA_W'(s); halfWidth = HW_W'(h); start = st;
    mStep(s, h, st);
    @(negedge clk);
    cmpAll();
  endtask

  task automatic run(int val, int n);
    for (int i = 0; i < n; i++) cyc(val, 0, 0);
  endtask

  task automatic finish();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        finish();
      end
    end
  end

  initial begin
    mReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, then stimulus without start has no effect
    chk(threshold == 0 && avgLen == 0 && avgEnergy == 0, "R1 outputs after reset",
        threshold + avgLen, 0);
    chk(done == 0, "R1 done after reset", done, 0);
    for (int i = 0; i < 12; i++) cyc(40, 9, 0);
    chk(threshold == 0 && !done, "R1 idle ignores inputs", threshold, 0);

    // R2: threshold from half-width values 5,6,7,9 -> floor(27/4) = 6
    cyc(50, 1, 1);
    cyc(50, 5, 0); cyc(50, 6, 0); cyc(50, 7, 0); cyc(50, 9, 0);
    chk(threshold == 6, "R2 threshold average", threshold, 6);

    // length phase: 6, (holdoff-blocked 8), (short run 3), 9, 40->31, 8
    run(0, 3);
    run(10, 6); run(0, 5);
    run(10, 8); run(0, 30);   // R6: inside holdoff, ignored
    run(10, 3); run(0, 5);    // R3: run too short, ignored
    run(10, 9); run(0, 25);
    run(10, 40); run(0, 25);  // R5: capped at 31
    run(10, 8);
    cyc(0, 0, 0);
    chk(avgLen == 13, "R4 R5 R6 R3 avgLen from 6,9,31,8", avgLen, 13);

    // energy phase, avgLen = 13
    run(0, 25);
    run(10, 15); run(0, 5);
    run(30, 10); run(0, 25);  // R6: inside holdoff in energy phase
    run(20, 4); run(-2, 9); run(0, 25);  // R7: tail below zero still summed
    run(7, 13); run(0, 25);
    run(8, 20); run(0, 3);
    chk($signed(avgEnergy) == 96, "R7 avgEnergy floor(387/4)", $signed(avgEnergy), 96);
    chk(done == 1, "R8 done after energy phase", done, 1);

    // R8: inputs after completion change nothing
    run(25, 12); run(0, 4);
    chk(done && threshold == 6 && avgLen == 13 && $signed(avgEnergy) == 96,
        "R8 outputs hold", threshold, 6);

    // R9: restart clears and recalibrates
    cyc(0, 3, 1);
    chk(threshold == 0 && avgLen == 0 && avgEnergy == 0 && !done,
        "R9 start clears outputs", threshold + avgLen, 0);
    for (int i = 0; i < 4; i++) cyc(0, 3, 0);
    chk(threshold == 3, "R9 R2 threshold relearned", threshold, 3);
    // R9: start in mid length phase restarts the threshold phase
    run(10, 5);
    cyc(0, 8, 1);
    chk(threshold == 0 && !done, "R9 start mid run", threshold, 0);
    for (int i = 0; i < 4; i++) cyc(0, 8, 0);
    chk(threshold == 8, "R9 threshold after mid-run start", threshold, 8);
    run(0, 4);
    finish();
  end

endmodule